// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a data cache that sits between a processor and a main memory addressed by words. Each 16-bit word address is split into a tag, a line index and a word offset. The cache has 128 lines of 16 words. Every line carries a valid flag and a dirty flag. A read that hits is answered from the cache alone. A write that hits changes only the cached word and marks the line dirty.

On a miss the controller first copies a dirty victim line back to memory as one 16-word write burst. It then fetches the whole wanted line as one 16-word read burst. A read miss gets its word in the same cycle that memory returns it (load-through). A write miss allocates the line and merges the write data into it during the refill.

The processor side uses a request/ready handshake. The memory side uses a command/grant handshake followed by data beats, with one word per beat.

Top module: `wb_dm_cache`

## Requirements
- R1: The address splits as tag = addr[15:11], line index = addr[10:4] and offset = addr[3:0], so memory block j (addr[15:4]) shares cache line j mod 128 with every block whose addr[10:4] is the same. Filling one line leaves all other lines resident.
- R2: Reset clears every valid flag and every dirty flag. After reset, every access misses, and no write-back is made for lines that were dirty before the reset.
- R3: A read that hits (valid line, stored tag equal to addr[15:11]) raises cpu_rvalid with the stored word one cycle after it is accepted, and raises no mem_req.
- R4: A write that hits updates the cached word, raises no mem_req and no cpu_rvalid, and marks the line dirty. A later read of that word returns the written data.
- R5: A miss issues a read command on mem_req with mem_we=0 and mem_addr = {tag, index, 4'b0000}. The command stays asserted with a stable address until mem_gnt.
- R6: The refill accepts words in ascending offset order from offset 0, one per mem_rvalid. For a read miss, cpu_rvalid is high, and cpu_rdata equals mem_rdata, in exactly the cycle that the word at the requested offset arrives.
- R7: A write miss fetches the line, stores cpu_wdata in place of the fetched word at the requested offset, gives no cpu_rvalid, and leaves the line dirty. A later eviction writes back the new word together with the fetched words.
- R8: When the victim line is valid and dirty, a write command (mem_we=1) at {old tag, index, 4'b0000} is issued first. All 16 current words are then sent in offset order on mem_wdata, one per mem_wnext, while mem_wvalid is high. The refill read command follows only after that.
- R9: cpu_ready is high exactly when the controller is idle. It is low from the cycle after a miss is accepted, and it returns high one cycle after the last refill word.
- R10: A miss whose victim line is invalid or clean issues no write command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request; accepted when cpu_ready is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Controller idle, request can be accepted |
| cpu_rvalid | output | 1 | Read data valid (one-cycle pulse) |
| cpu_rdata | output | 32 | Read data |
| mem_req | output | 1 | Burst command valid |
| mem_we | output | 1 | Burst direction, 1 = write-back |
| mem_addr | output | 16 | Line base word address of the burst |
| mem_gnt | input | 1 | Command accepted |
| mem_wvalid | output | 1 | Write-back data present |
| mem_wdata | output | 32 | Write-back word |
| mem_wnext | input | 1 | Memory takes the current write-back word |
| mem_rvalid | input | 1 | Refill word valid |
| mem_rdata | input | 32 | Refill word |

## Verification
Reads are tried on cold lines, on resident lines and on lines that conflict through their index. This separates hits, which leave the memory side idle, from misses with clean victims and misses with dirty victims. The load-through timing is checked at offsets 0, 4 and 15, with a stalled beat inside the refill. These cases show whether the forwarded word is tied to the right beat rather than to the end of the line. Write hits and write misses are each followed by a read-back and then by a forced eviction. The write-back burst then shows whether the merged word and the dirty flag were kept. A mid-run reset followed by a read of a dirty line checks that both the valid flags and the dirty flags were dropped.

// File: rtl/cache_pkg.sv
`timescale 1ns/100ps
package cache_pkg;
    parameter int unsigned CACHE_ADDR_W = 16;
    parameter int unsigned CACHE_TAG_W  = 5;
    parameter int unsigned CACHE_IDX_W  = 7;
    parameter int unsigned CACHE_OFF_W  = 4;
    parameter int unsigned CACHE_DATA_W = 32;
    localparam int unsigned CACHE_LINES = 1 << CACHE_IDX_W;
    localparam int unsigned CACHE_WORDS = 1 << CACHE_OFF_W;
    localparam int unsigned CACHE_SLOT_W = CACHE_IDX_W + CACHE_OFF_W;

    typedef logic [CACHE_ADDR_W-1:0] addr_t;
    typedef logic [CACHE_TAG_W-1:0]  tag_t;
    typedef logic [CACHE_IDX_W-1:0]  idx_t;
    typedef logic [CACHE_OFF_W-1:0]  off_t;
    typedef logic [CACHE_DATA_W-1:0] data_t;
    typedef logic [CACHE_SLOT_W-1:0] slot_t;

    typedef struct packed {
        tag_t tag;
        idx_t idx;
        off_t off;
    } addr_fields_t;

    typedef struct packed {
        logic         we;
        addr_fields_t a;
        data_t        wdata;
    } pend_req_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WB_CMD,
        ST_WB_BEAT,
        ST_RF_CMD,
        ST_RF_BEAT
    } ctrl_state_t;

    function automatic addr_t line_base(input tag_t t, input idx_t i);
        return {t, i, {CACHE_OFF_W{1'b0}}};
    endfunction

    function automatic slot_t slot_of(input idx_t i, input off_t o);
        return {i, o};
    endfunction
endpackage

// File: rtl/cache_tag_store.sv
`timescale 1ns/100ps
module cache_tag_store
    import cache_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  idx_t lk_idx,
    output tag_t lk_tag,
    output logic lk_valid,
    output logic lk_dirty,
    input  logic fill_en,
    input  idx_t fill_idx,
    input  tag_t fill_tag,
    input  logic fill_dirty,
    input  logic mark_en,
    input  idx_t mark_idx
);
    logic [CACHE_LINES-1:0] valid_vec;
    logic [CACHE_LINES-1:0] dirty_vec;
    tag_t                   tag_arr [CACHE_LINES];

    for (genvar g = 0; g < CACHE_LINES; g++) begin : g_line
        localparam idx_t LINE_ID = idx_t'(g);
        logic v_q;
        logic d_q;
        tag_t t_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
                t_q <= '0;
            end else if (fill_en && fill_idx == LINE_ID) begin
                v_q <= 1'b1;
                d_q <= fill_dirty;
                t_q <= fill_tag;
            end else if (mark_en && mark_idx == LINE_ID) begin
                d_q <= 1'b1;
            end
        end
        assign valid_vec[g] = v_q;
        assign dirty_vec[g] = d_q;
        assign tag_arr[g]   = t_q;
    end

    assign lk_tag   = tag_arr[lk_idx];
    assign lk_valid = valid_vec[lk_idx];
    assign lk_dirty = dirty_vec[lk_idx];
endmodule

// File: rtl/cache_data_store.sv
`timescale 1ns/100ps
module cache_data_store
    import cache_pkg::*;
(
    input  logic  clk,
    input  slot_t rd_slot,
    output data_t rd_data,
    input  logic  wr_en,
    input  slot_t wr_slot,
    input  data_t wr_data
);
    localparam int unsigned DEPTH = CACHE_LINES * CACHE_WORDS;

    data_t store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[wr_slot] <= wr_data;
        end
    end

    assign rd_data = store_q[rd_slot];
endmodule

// File: rtl/cache_ctrl.sv
`timescale 1ns/100ps
module cache_ctrl
    import cache_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cpu_req,
    input  logic  cpu_we,
    input  addr_t cpu_addr,
    input  data_t cpu_wdata,
    output logic  cpu_ready,
    output logic  cpu_rvalid,
    output data_t cpu_rdata,
    output idx_t  lk_idx,
    input  tag_t  lk_tag,
    input  logic  lk_valid,
    input  logic  lk_dirty,
    output logic  fill_en,
    output idx_t  fill_idx,
    output tag_t  fill_tag,
    output logic  fill_dirty,
    output logic  mark_en,
    output idx_t  mark_idx,
    output slot_t d_rslot,
    input  data_t d_rdata,
    output logic  d_wen,
    output slot_t d_wslot,
    output data_t d_wdata,
    output logic  mem_req,
    output logic  mem_we,
    output addr_t mem_addr,
    input  logic  mem_gnt,
    output logic  mem_wvalid,
    output data_t mem_wdata,
    input  logic  mem_wnext,
    input  logic  mem_rvalid,
    input  data_t mem_rdata
);
    localparam off_t LAST_BEAT = off_t'(CACHE_WORDS - 1);

    ctrl_state_t  state_q;
    pend_req_t    pend_q;
    tag_t         vtag_q;
    off_t         beat_q;
    logic         hit_rv_q;
    data_t        hit_rd_q;

    addr_fields_t in_f;
    logic         idle;
    logic         accept;
    logic         hit;
    logic         rf_beat;
    logic         rf_own_word;
    logic         lt_fwd;

    assign in_f        = addr_fields_t'(cpu_addr);
    assign idle        = (state_q == ST_IDLE);
    assign accept      = idle && cpu_req;
    assign lk_idx      = idle ? in_f.idx : pend_q.a.idx;
    assign hit         = lk_valid && (lk_tag == in_f.tag);
    assign rf_beat     = (state_q == ST_RF_BEAT) && mem_rvalid;
    assign rf_own_word = rf_beat && (beat_q == pend_q.a.off);
    assign lt_fwd      = rf_own_word && !pend_q.we;

    // processor side
    assign cpu_ready  = idle;
    assign cpu_rvalid = hit_rv_q || lt_fwd;
    assign cpu_rdata  = lt_fwd ? mem_rdata : hit_rd_q;

    // data array access
    assign d_rslot = idle ? slot_of(in_f.idx, in_f.off) : slot_of(pend_q.a.idx, beat_q);
    assign d_wen   = (accept && hit && cpu_we) || rf_beat;
    assign d_wslot = rf_beat ? slot_of(pend_q.a.idx, beat_q) : slot_of(in_f.idx, in_f.off);
    always_comb begin
        if (!rf_beat) begin
            d_wdata = cpu_wdata;
        end else if (rf_own_word && pend_q.we) begin
            d_wdata = pend_q.wdata;
        end else begin
            d_wdata = mem_rdata;
        end
    end

    // tag / flag updates
    assign mark_en    = accept && hit && cpu_we;
    assign mark_idx   = in_f.idx;
    assign fill_en    = rf_beat && (beat_q == LAST_BEAT);
    assign fill_idx   = pend_q.a.idx;
    assign fill_tag   = pend_q.a.tag;
    assign fill_dirty = pend_q.we;

    // memory side
    assign mem_req    = (state_q == ST_WB_CMD) || (state_q == ST_RF_CMD);
    assign mem_we     = (state_q == ST_WB_CMD);
    assign mem_addr   = (state_q == ST_WB_CMD) ? line_base(vtag_q, pend_q.a.idx)
                                               : line_base(pend_q.a.tag, pend_q.a.idx);
    assign mem_wvalid = (state_q == ST_WB_BEAT);
    assign mem_wdata  = d_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            pend_q   <= '0;
            vtag_q   <= '0;
            beat_q   <= '0;
            hit_rv_q <= 1'b0;
            hit_rd_q <= '0;
        end else begin
            hit_rv_q <= accept && hit && !cpu_we;
            if (accept && hit && !cpu_we) begin
                hit_rd_q <= d_rdata;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (accept && !hit) begin
                        pend_q.we    <= cpu_we;
                        pend_q.a     <= in_f;
                        pend_q.wdata <= cpu_wdata;
                        vtag_q       <= lk_tag;
                        state_q      <= (lk_valid && lk_dirty) ? ST_WB_CMD : ST_RF_CMD;
                    end
                end
                ST_WB_CMD: begin
                    if (mem_gnt) begin
                        beat_q  <= '0;
                        state_q <= ST_WB_BEAT;
                    end
                end
                ST_WB_BEAT: begin
                    if (mem_wnext) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == LAST_BEAT) begin
                            state_q <= ST_RF_CMD;
                        end
                    end
                end
                ST_RF_CMD: begin
                    if (mem_gnt) begin
                        beat_q  <= '0;
                        state_q <= ST_RF_BEAT;
                    end
                end
                ST_RF_BEAT: begin
                    if (mem_rvalid) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == LAST_BEAT) begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wb_dm_cache.sv
`timescale 1ns/100ps
module wb_dm_cache
    import cache_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [15:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_ready,
    output logic        cpu_rvalid,
    output logic [31:0] cpu_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    input  logic        mem_gnt,
    output logic        mem_wvalid,
    output logic [31:0] mem_wdata,
    input  logic        mem_wnext,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata
);
    idx_t  lk_idx;
    tag_t  lk_tag;
    logic  lk_valid;
    logic  lk_dirty;
    logic  fill_en;
    idx_t  fill_idx;
    tag_t  fill_tag;
    logic  fill_dirty;
    logic  mark_en;
    idx_t  mark_idx;
    slot_t d_rslot;
    data_t d_rdata;
    logic  d_wen;
    slot_t d_wslot;
    data_t d_wdata;

    cache_ctrl i_ctrl (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_valid(lk_valid), .lk_dirty(lk_dirty),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_dirty(fill_dirty),
        .mark_en(mark_en), .mark_idx(mark_idx),
        .d_rslot(d_rslot), .d_rdata(d_rdata), .d_wen(d_wen), .d_wslot(d_wslot), .d_wdata(d_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_wvalid(mem_wvalid), .mem_wdata(mem_wdata), .mem_wnext(mem_wnext),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    cache_tag_store i_tags (
        .clk(clk), .rst(rst),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_valid(lk_valid), .lk_dirty(lk_dirty),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_dirty(fill_dirty),
        .mark_en(mark_en), .mark_idx(mark_idx)
    );

    cache_data_store i_data (
        .clk(clk),
        .rd_slot(d_rslot), .rd_data(d_rdata),
        .wr_en(d_wen), .wr_slot(d_wslot), .wr_data(d_wdata)
    );
endmodule

// File: rtl/wb_dm_cache_chk.sv
`timescale 1ns/100ps
module wb_dm_cache_chk
    import cache_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cpu_req,
    input logic        cpu_we,
    input logic        cpu_ready,
    input logic        cpu_rvalid,
    input logic [31:0] cpu_rdata,
    input logic        mem_req,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic        mem_gnt,
    input logic        mem_wvalid,
    input logic        mem_wnext,
    input logic        mem_rvalid,
    input logic [31:0] mem_rdata
);
    localparam int unsigned CNT_W = CACHE_OFF_W + 1;

    logic [CNT_W-1:0] wb_beats;

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_beats <= '0;
        end else if (mem_req && !mem_we && mem_gnt) begin
            wb_beats <= '0;
        end else if (mem_wvalid && mem_wnext) begin
            wb_beats <= wb_beats + 1'b1;
        end
    end

    AST_READY_MEM_QUIET: assert property (@(posedge clk) disable iff (rst) cpu_ready |-> !mem_req && !mem_wvalid); // R9
    AST_HIT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst) (cpu_rvalid && !mem_rvalid) |-> $past(cpu_ready && cpu_req && !cpu_we)); // R3
    AST_LOADTHRU_WORD: assert property (@(posedge clk) disable iff (rst) (cpu_rvalid && mem_rvalid) |-> (cpu_rdata == mem_rdata)); // R6
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst) (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R5
    AST_CMD_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst) mem_req |-> (mem_addr[CACHE_OFF_W-1:0] == '0)); // R5
    AST_WB_WHOLE_LINE: assert property (@(posedge clk) disable iff (rst) (mem_req && !mem_we) |-> (wb_beats == '0 || wb_beats == CNT_W'(CACHE_WORDS))); // R8
endmodule

bind wb_dm_cache wb_dm_cache_chk i_chk (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_wvalid(mem_wvalid), .mem_wnext(mem_wnext),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
);

// File: tb/test_wb_dm_cache.sv
`timescale 1ns/100ps
module test_wb_dm_cache;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic        cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic        mem_gnt = 1'b0;
    logic        mem_wvalid;
    logic [31:0] mem_wdata;
    logic        mem_wnext = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int total = 0;
    int bad = 0;

    // memory model and monitor state
    int          ph = 0;
    int          beat = 0;
    bit          stalled = 0;
    logic [15:0] base = '0;
    int          seq = 0;
    int          rd_cmds = 0, wr_cmds = 0, rd_seq = 0, wr_seq = 0;
    logic [15:0] rd_addr = '0, wr_addr = '0;
    logic [31:0] wb_log [16];
    int          rv_cnt = 0;
    logic [31:0] rv_data = '0;
    bit          rv_lt = 0;
    int          rv_off = -1;
    int          cur_off = 0;
    int          cyc_n = 0;
    int          last_beat_cyc = 0;
    int          ready_gap = 0;
    bit          rdy_prev = 1;
    int          busy_rdy = 0;

    localparam logic [31:0] D1 = 32'hC0DE_0001;
    localparam logic [31:0] D2 = 32'hBEEF_0002;
    localparam logic [31:0] D3 = 32'hFACE_0003;

    wb_dm_cache i_wb_dm_cache (.*);

    always #2.5 clk = ~clk;

    function automatic logic [31:0] mval(input logic [15:0] a);
        return {a ^ 16'h5A3C, a};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // memory responder: drives at negedge, samples outputs 1 ns later
    initial begin
        forever begin
            @(negedge clk);
            cyc_n++;
            mem_gnt = 1'b0;
            mem_rvalid = 1'b0;
            mem_wnext = 1'b0;
            if (rst) begin
                ph = 0;
            end else begin
                case (ph)
                    0: if (mem_req) begin
                        mem_gnt = 1'b1;
                        seq++;
                        base = mem_addr;
                        beat = 0;
                        stalled = 0;
                        if (mem_we) begin
                            ph = 1; wr_cmds++; wr_addr = mem_addr; wr_seq = seq;
                        end else begin
                            ph = 2; rd_cmds++; rd_addr = mem_addr; rd_seq = seq;
                        end
                    end
                    1: if (beat == 7 && !stalled) begin
                        stalled = 1;
                    end else begin
                        mem_wnext = 1'b1;
                        wb_log[beat] = mem_wdata;
                        beat++;
                        if (beat == 16) ph = 0;
                    end
                    default: if (beat == 2 && !stalled) begin
                        stalled = 1;
                    end else begin
                        mem_rvalid = 1'b1;
                        mem_rdata = mval(base | 16'(beat));
                        cur_off = beat;
                        beat++;
                        if (beat == 16) begin
                            ph = 0;
                            last_beat_cyc = cyc_n;
                        end
                    end
                endcase
            end
            #1;
            if (!rst) begin
                if (cpu_rvalid) begin
                    rv_cnt++;
                    rv_data = cpu_rdata;
                    rv_lt = mem_rvalid;
                    rv_off = mem_rvalid ? cur_off : -1;
                end
                if (cpu_ready && !rdy_prev) ready_gap = cyc_n - last_beat_cyc;
                if (cpu_ready && ph != 0) busy_rdy++;
                rdy_prev = cpu_ready;
            end
        end
    end

    task automatic cpu_op(input bit we, input logic [15:0] a, input logic [31:0] d);
        int n;
        n = 0;
        @(negedge clk);
        while (!cpu_ready && n < 1000) begin @(negedge clk); n++; end
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0;
        n = 0;
        while (!cpu_ready && n < 1000) begin @(negedge clk); n++; end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset_state();
        check(cpu_ready == 1'b1, "R9 ready after reset", 32'(cpu_ready), 1);
        check(cpu_rvalid == 1'b0, "R3 no rvalid after reset", 32'(cpu_rvalid), 0);
        check(mem_req == 1'b0, "R2 no mem_req after reset", 32'(mem_req), 0);
    endtask

    task automatic t_cold_read();
        int r0 = rd_cmds, w0 = wr_cmds, v0 = rv_cnt;
        cpu_op(0, 16'h1234, 0);
        check(rd_cmds == r0 + 1, "R2 cold access misses", rd_cmds, r0 + 1);
        check(rd_addr == 16'h1230, "R5 refill base address", rd_addr, 16'h1230);
        check(wr_cmds == w0, "R10 no write-back on invalid victim", wr_cmds, w0);
        check(rv_cnt == v0 + 1, "R6 one forwarded word", rv_cnt, v0 + 1);
        check(rv_data == mval(16'h1234), "R6 forwarded data", rv_data, mval(16'h1234));
        check(rv_lt == 1'b1 && rv_off == 4, "R6 forwarded with beat of offset 4", rv_off, 4);
        check(ready_gap == 1, "R9 ready one cycle after last word", ready_gap, 1);
    endtask

    task automatic t_read_hit();
        int r0 = rd_cmds, w0 = wr_cmds, v0 = rv_cnt;
        cpu_op(0, 16'h123F, 0);
        check(rd_cmds == r0 && wr_cmds == w0, "R3 hit makes no memory command", rd_cmds, r0);
        check(rv_cnt == v0 + 1 && rv_lt == 1'b0, "R3 hit rvalid from cache", rv_cnt, v0 + 1);
        check(rv_data == mval(16'h123F), "R3 hit data", rv_data, mval(16'h123F));
    endtask

    task automatic t_write_hit();
        int r0 = rd_cmds, w0 = wr_cmds, v0 = rv_cnt;
        cpu_op(1, 16'h1235, D1);
        check(rd_cmds == r0 && wr_cmds == w0, "R4 write hit no memory command", rd_cmds, r0);
        check(rv_cnt == v0, "R4 write hit no rvalid", rv_cnt, v0);
        cpu_op(0, 16'h1235, 0);
        check(rv_data == D1, "R4 read back written word", rv_data, D1);
        check(rd_cmds == r0, "R4 read back is a hit", rd_cmds, r0);
    endtask

    task automatic t_edge_offsets();
        cpu_op(0, 16'h4560, 0);
        check(rv_off == 0 && rv_lt == 1'b1, "R6 offset 0 forwarded on first beat", rv_off, 0);
        check(rv_data == mval(16'h4560), "R6 offset 0 data", rv_data, mval(16'h4560));
        cpu_op(0, 16'h789F, 0);
        check(rv_off == 15 && rv_lt == 1'b1, "R6 offset 15 forwarded on last beat", rv_off, 15);
        check(rv_data == mval(16'h789F), "R6 offset 15 data", rv_data, mval(16'h789F));
        check(ready_gap == 1, "R9 ready gap after offset 15 miss", ready_gap, 1);
    endtask

    task automatic t_dirty_evict();
        int w0 = wr_cmds, r0 = rd_cmds;
        cpu_op(0, 16'h1A34, 0);
        check(wr_cmds == w0 + 1, "R8 dirty victim written back", wr_cmds, w0 + 1);
        check(wr_addr == 16'h1230, "R8 write-back base address", wr_addr, 16'h1230);
        check(wb_log[5] == D1, "R8 modified word written back", wb_log[5], D1);
        check(wb_log[0] == mval(16'h1230), "R8 word 0 written back", wb_log[0], mval(16'h1230));
        check(wb_log[4] == mval(16'h1234), "R8 word 4 written back", wb_log[4], mval(16'h1234));
        check(wb_log[15] == mval(16'h123F), "R8 word 15 written back", wb_log[15], mval(16'h123F));
        check(wr_seq < rd_seq && rd_cmds == r0 + 1, "R8 write-back before refill", wr_seq, rd_seq);
        check(rd_addr == 16'h1A30, "R1 block j+128 refills same line", rd_addr, 16'h1A30);
        check(rv_data == mval(16'h1A34), "R1 new tag data", rv_data, mval(16'h1A34));
        r0 = rd_cmds;
        cpu_op(0, 16'h1A34, 0);
        check(rd_cmds == r0 && rv_data == mval(16'h1A34), "R1 new line hits", rd_cmds, r0);
        cpu_op(0, 16'h4561, 0);
        check(rd_cmds == r0 && rv_data == mval(16'h4561), "R1 other line still resident", rd_cmds, r0);
    endtask

    task automatic t_clean_evict();
        int w0 = wr_cmds, r0 = rd_cmds;
        cpu_op(0, 16'h4D60, 0);
        check(wr_cmds == w0, "R10 clean victim no write-back", wr_cmds, w0);
        check(rd_cmds == r0 + 1 && rd_addr == 16'h4D60, "R5 conflict refill address", rd_addr, 16'h4D60);
        check(rv_data == mval(16'h4D60), "R6 conflict data", rv_data, mval(16'h4D60));
    endtask

    task automatic t_write_miss();
        int w0 = wr_cmds, r0 = rd_cmds, v0 = rv_cnt;
        cpu_op(1, 16'h0105, D2);
        check(rd_cmds == r0 + 1 && rd_addr == 16'h0100, "R7 write miss fetches line", rd_addr, 16'h0100);
        check(wr_cmds == w0, "R10 write miss invalid victim no write-back", wr_cmds, w0);
        check(rv_cnt == v0, "R7 write miss no rvalid", rv_cnt, v0);
        check(ready_gap == 1, "R9 ready gap after write miss", ready_gap, 1);
        r0 = rd_cmds;
        cpu_op(0, 16'h0105, 0);
        check(rv_data == D2 && rd_cmds == r0, "R7 merged word reads back", rv_data, D2);
        cpu_op(0, 16'h0106, 0);
        check(rv_data == mval(16'h0106), "R7 fetched neighbour word", rv_data, mval(16'h0106));
        cpu_op(0, 16'h0905, 0);
        check(wr_cmds == w0 + 1 && wr_addr == 16'h0100, "R7 allocated line is dirty", wr_cmds, w0 + 1);
        check(wb_log[5] == D2, "R7 write data in write-back", wb_log[5], D2);
        check(wb_log[6] == mval(16'h0106), "R7 fetched word in write-back", wb_log[6], mval(16'h0106));
    endtask

    task automatic t_reset_invalidate();
        int w0, r0;
        cpu_op(1, 16'h1A34, D3);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rdy_prev = 1;
        w0 = wr_cmds;
        r0 = rd_cmds;
        cpu_op(0, 16'h1A34, 0);
        check(rd_cmds == r0 + 1, "R2 resident line misses after reset", rd_cmds, r0 + 1);
        check(wr_cmds == w0, "R2 dirty flag cleared by reset", wr_cmds, w0);
        check(rv_data == mval(16'h1A34), "R2 data from memory after reset", rv_data, mval(16'h1A34));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R9 act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        t_reset_state();
        t_cold_read();
        t_read_hit();
        t_write_hit();
        t_edge_offsets();
        t_dirty_evict();
        t_clean_evict();
        t_write_miss();
        t_reset_invalidate();
        check(busy_rdy == 0, "R9 ready low while a burst is open", busy_rdy, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule